// File: doc/BRIEF.md
# Delayed Sweep Gating Controller

This block governs a second, delayed time-base that runs inside each sweep of a main time-base. The main time-base controller is outside the block; it supplies an activity flag, its current sweep position as a counter value, and a one-cycle pulse when its sweep ends. The block compares that position with a programmable delay value. The delay point counts as reached as soon as the position is greater than or equal to the delay value, so a coarse position step that jumps over the exact value is still caught.

Once the delay point is reached, a source-select input decides what happens next. With the immediate source, the delayed sweep begins straight away. With the trigger source, the block only arms and then waits for a trigger pulse that arrives after the delay point. The delayed sweep lasts a number of cycles taken from a programmable length input. It is cut short when the main sweep ends. At most one delayed sweep runs per main sweep, and an armed state that never saw a trigger is dropped when the main sweep ends.

The outputs are a gate that is high only while the delayed sweep runs, a flag that shows the delay point has been passed in the current main sweep, and one-cycle start and end pulses. All outputs come from registers.

Top module: `dly_sweep_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, dgate, dly_reached, start_pulse and end_pulse are all 0.
- R2: The delay point is a cycle with main_active=1 and main_pos >= dly_val (unsigned). dly_reached goes to 1 on the clock edge of the first such cycle in a main sweep. It stays 1 until the edge of the cycle where main_end=1, after which it is 0.
- R3: With src_sel=0 (immediate source), dgate and start_pulse both go to 1 on the edge of the delay-point cycle.
- R4: With src_sel=1 (trigger source), the delay point only arms the block. dgate and start_pulse go to 1 on the edge of the first cycle with trig=1 that comes strictly after the delay-point cycle and before main_end. A trig in the delay-point cycle or earlier is ignored.
- R5: A delayed sweep keeps dgate at 1 for max(len_val,1) cycles. end_pulse is 1 in the first cycle after that in which dgate is back at 0.
- R6: At most one delayed sweep starts per main sweep. Triggers after a completed delayed sweep have no effect until the next main sweep. An armed state with no trigger is cleared by main_end.
- R7: If main_end=1 while a delayed sweep runs, dgate is 0 from the next edge on and end_pulse is 1 in that cycle.
- R8: start_pulse and end_pulse are single-cycle pulses. start_pulse is 1 only in the first dgate cycle of a delayed sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_active | input | 1 | Main sweep in progress |
| main_end | input | 1 | One-cycle pulse at the end of the main sweep |
| main_pos | input | POS_W | Current main sweep position |
| dly_val | input | POS_W | Delay value compared with main_pos |
| len_val | input | LEN_W | Delayed sweep length in cycles (0 acts as 1) |
| src_sel | input | 1 | 0: start at delay point, 1: arm and wait for trig |
| trig | input | 1 | Trigger pulse for the trigger source |
| dgate | output | 1 | High while the delayed sweep runs |
| dly_reached | output | 1 | Delay point passed in the current main sweep |
| start_pulse | output | 1 | One-cycle pulse at delayed sweep start |
| end_pulse | output | 1 | One-cycle pulse at delayed sweep end |

## Verification
The bench builds the block with POS_W=5 and LEN_W=3, so every main sweep of eight positions fits in a small range. The bench sweeps position steps of 1 and 3, every delay value from 0 to 9 (this includes values that are skipped and values that are never reached), every length from 0 to 3, both source settings, and a trigger placed at every cycle of the sweep with a second trigger after it. That brings within reach: triggers before, at and after the delay point; truncation by main_end; triggers that must be ignored after a completed delayed sweep; and back-to-back main sweeps without reset. Expected outputs are derived arithmetically from the hit index, the trigger index and the length.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } dsg_state_t;

    typedef struct packed {
        dsg_state_t st;
        logic       start;
        logic       stop;
    } dsg_regs_t;

endpackage

// File: rtl/dsg_delay_cmp.sv
module dsg_delay_cmp #(
    parameter int POS_W = 12
) (
    input  logic             active,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] dly,
    output logic             hit
);
    // Greater-or-equal so a skipped exact value still counts as reached.
    always_comb begin
        hit = active && (pos >= dly);
    end
endmodule

// File: rtl/dsg_len_cnt.sv
module dsg_len_cnt #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    localparam int EXT_W = LEN_W + 1;

    logic [LEN_W-1:0] cnt_d, cnt_q;
    logic [EXT_W-1:0] cnt_next_ext;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + 1'b1;
        cnt_next_ext = {1'b0, cnt_q} + 1'b1;
        last = cnt_next_ext >= {1'b0, len};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assert_clr_inc_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && inc));
    assert_clr_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/dsg_fsm.sv
module dsg_fsm
    import dsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic main_end,
    input  logic src_sel,
    input  logic trig,
    input  logic last,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic gate,
    output logic reached,
    output logic start_p,
    output logic stop_p
);
    dsg_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.stop  = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!main_end && hit) begin
                    if (!src_sel) begin
                        r_d.st    = ST_RUN;
                        r_d.start = 1'b1;
                        cnt_clr   = 1'b1;
                    end else begin
                        r_d.st = ST_ARMED;
                    end
                end
            end
            ST_ARMED: begin
                if (main_end) begin
                    r_d.st = ST_IDLE;
                end else if (trig) begin
                    r_d.st    = ST_RUN;
                    r_d.start = 1'b1;
                    cnt_clr   = 1'b1;
                end
            end
            ST_RUN: begin
                if (main_end) begin
                    r_d.st   = ST_IDLE;
                    r_d.stop = 1'b1;
                end else if (last) begin
                    r_d.st   = ST_DONE;
                    r_d.stop = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: begin
                if (main_end)
                    r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.start <= 1'b0;
            r_q.stop  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate    = (r_q.st == ST_RUN);
    assign reached = (r_q.st != ST_IDLE);
    assign start_p = r_q.start;
    assign stop_p  = r_q.stop;

    assert_rise_has_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> start_p);
    assert_fall_has_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> stop_p);
    assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> !start_p);
    assert_end_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !stop_p);
    assert_main_end_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        main_end |=> (!gate && !reached));
    assert_immediate_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && hit && !main_end && !src_sel) |=> (gate && start_p));
    assert_armed_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ARMED && !trig) |=> !gate);
    assert_once_per_sweep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DONE) |=> !gate);
endmodule

// File: rtl/dly_sweep_ctrl.sv
module dly_sweep_ctrl #(
    parameter int POS_W = 12,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_active,
    input  logic             main_end,
    input  logic [POS_W-1:0] main_pos,
    input  logic [POS_W-1:0] dly_val,
    input  logic [LEN_W-1:0] len_val,
    input  logic             src_sel,
    input  logic             trig,
    output logic             dgate,
    output logic             dly_reached,
    output logic             start_pulse,
    output logic             end_pulse
);
    logic hit;
    logic last;
    logic cnt_clr;
    logic cnt_inc;

    dsg_delay_cmp #(.POS_W(POS_W)) u_cmp (
        .active (main_active),
        .pos    (main_pos),
        .dly    (dly_val),
        .hit    (hit)
    );

    dsg_len_cnt #(.LEN_W(LEN_W)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .len   (len_val),
        .last  (last)
    );

    dsg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .main_end (main_end),
        .src_sel  (src_sel),
        .trig     (trig),
        .last     (last),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .gate     (dgate),
        .reached  (dly_reached),
        .start_p  (start_pulse),
        .stop_p   (end_pulse)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!dgate && !dly_reached && !start_pulse && !end_pulse));
    assert_gate_needs_reach_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dgate |-> dly_reached);
endmodule

// File: tb/dly_sweep_ctrl_test.sv
`timescale 1ns/100ps
module dly_sweep_ctrl_test;
    localparam int PW = 5;
    localparam int LW = 3;
    localparam int M  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          main_active = 1'b0;
    logic          main_end = 1'b0;
    logic [PW-1:0] main_pos = '0;
    logic [PW-1:0] dly_val = '0;
    logic [LW-1:0] len_val = '0;
    logic          src_sel = 1'b0;
    logic          trig = 1'b0;
    logic          dgate, dly_reached, start_pulse, end_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dly_sweep_ctrl #(.POS_W(PW), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .main_active(main_active), .main_end(main_end),
        .main_pos(main_pos), .dly_val(dly_val), .len_val(len_val), .src_sel(src_sel),
        .trig(trig), .dgate(dgate), .dly_reached(dly_reached),
        .start_pulse(start_pulse), .end_pulse(end_pulse)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic run_sweep(input int src, input int step, input int dly, input int len, input int t);
        int h, s, endk, l, t2;
        h = -1;
        for (int i = 0; i < M; i++)
            if (h < 0 && i * step >= dly) h = i;
        l  = (len == 0) ? 1 : len;
        t2 = t + l + 1;
        s  = -1;
        if (h >= 0) begin
            if (src == 0) s = h;
            else if (t > h && t < M) s = t;
            else if (t2 > h && t2 < M) s = t2;
        end
        endk = -1;
        if (s >= 0) endk = (s + l < M) ? s + l : M;
        src_sel = src[0];
        dly_val = PW'(dly);
        len_val = LW'(len);
        for (int k = 0; k <= M + 1; k++) begin
            logic eg, es, ee, er;
            main_active = (k < M);
            main_pos    = (k < M) ? PW'(k * step) : '0;
            main_end    = (k == M);
            trig        = (k == t) || (k == t2);
            @(posedge clk); #1;
            eg = (s >= 0) && (k >= s) && (k < s + l) && (k < M);
            es = (k == s);
            ee = (k == endk);
            er = (h >= 0) && (k >= h) && (k < M);
            check("R2", "dly_reached", dly_reached, er);
            check(src == 0 ? "R3" : "R4", "start_pulse", start_pulse, es);
            if (endk >= 0 && k > endk)
                check("R6", "dgate after sweep", dgate, eg);
            else
                check("R5", "dgate", dgate, eg);
            check((endk == M) ? "R7" : "R5", "end_pulse", end_pulse, ee);
            if (k == s + 1)
                check("R8", "start single", start_pulse, 1'b0);
        end
        trig = 1'b0;
        main_end = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "dgate in reset", dgate, 1'b0);
        check("R1", "dly_reached in reset", dly_reached, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", "start_pulse after reset", start_pulse, 1'b0);
        check("R1", "end_pulse after reset", end_pulse, 1'b0);
        for (int src = 0; src < 2; src++)
            for (int stp = 0; stp < 2; stp++)
                for (int dly = 0; dly < 10; dly++)
                    for (int len = 0; len < 4; len++)
                        for (int t = 0; t < 10; t++)
                            run_sweep(src, (stp == 0) ? 1 : 3, dly, len, t);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule